// File: doc/BRIEF.md
# Double-Buffered DAC Code Register Bank

This block holds the input codes for a group of DAC channels. Each channel keeps two 12-bit straight-binary codes. The staging copy is what the host writes. The live copy drives the channel's output code bus. A host reaches the bank over a byte-wide register bus. Writes to a channel's data addresses only touch its staging copy. A single update command then moves every staging copy into the live copy at once, so all channel outputs change together.

A configuration bit chooses which copy data reads return. A per-channel clear input forces that channel's output code to zero without disturbing either stored copy. While a channel is cleared, a read of its live copy also returns zero. When clear is released, the stored live code reappears at once. Staging writes and update commands keep working while channels are cleared.

The register bus uses a valid/ready request channel and a valid/ready read-response channel. A request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` is low only while a read response is waiting and `rsp_ready` is low, so the host cannot overrun the single response slot. A waiting response holds its data steady until it is taken.

Top module: `dac_dbuf_bank`

## Requirements
- R1: After reset, all staging and live codes are zero, every output code is zero, readback selects the staging copy, and no response is pending.
- R2: Channel k uses data address 0x50+2k for code bits 7:0 and 0x51+2k for code bits 11:8 in bits 3:0. Bits 7:4 at the odd address are ignored on write and read as zero.
- R3: A data write changes only the addressed channel's staging byte. No output code and no live code changes because of it.
- R4: Writing a byte with bit 0 set to address 0x0F copies every staging code into its live code. The outputs show the new codes in the cycle after the write is accepted. Writing 0x0F with bit 0 clear has no effect.
- R5: A read of address 0x0F always returns zero.
- R6: Bit 0 of address 0x01 selects the source for data reads: 0 returns the staging copy and 1 returns the live copy. The register reads back as {7'b0, bit}.
- R7: While clr_ch[k] is high, output code k is zero and live reads of channel k return zero. Staging reads of channel k are unaffected. When clear drops, the stored live code appears again in the same cycle.
- R8: Staging writes and update commands issued while a channel is cleared are stored, and they appear on its output once clear drops.
- R9: A request is accepted when req_valid and req_ready are both high, and req_ready = !rsp_valid || rsp_ready. A read response is valid in the cycle after acceptance and holds its data until rsp_ready is high.
- R10: Reads from addresses outside 0x01, 0x0F and 0x50–0x6F return zero. Writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Register address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Host takes the response |
| rsp_rdata | output | 8 | Read response byte |
| clr_ch | input | 16 | Per-channel clear, active high |
| dac_code | output | 192 | Output codes, channel k at bits 12k+11:12k |

## Verification
The update command and the clear input can act on the same channel in the same cycle. The live copy is reloaded while its output is forced to zero. The bench holds clear on channel 0, writes a new staging code, and issues the update while clear is still high. It checks that the output stays zero, that a live read still returns zero, and that the staging read shows the new byte. When clear drops, the bench expects the newly updated code at the output in that same cycle, not the code that was live before the clear.

// File: rtl/dac_bank_pkg.sv
package dac_bank_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_CFG  = 2'd1,
    SEL_UPD  = 2'd2,
    SEL_DATA = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/dac_addr_dec.sv
module dac_addr_dec
  import dac_bank_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NUM_CH = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h50,
  parameter logic [ADDR_W-1:0] CFG_ADDR  = 8'h01,
  parameter logic [ADDR_W-1:0] UPD_ADDR  = 8'h0F,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel,
  output logic [CH_W-1:0]   ch,
  output logic              hi
);
  localparam int SPAN = 2 * NUM_CH;

  logic [ADDR_W-1:0] off;
  logic              in_data;

  assign off     = addr - BASE_ADDR;
  assign in_data = (addr >= BASE_ADDR) && ({1'b0, off} < (ADDR_W+1)'(SPAN));
  assign ch      = off[CH_W:1];
  assign hi      = off[0];

  always_comb begin
    if (in_data)               sel = SEL_DATA;
    else if (addr == CFG_ADDR) sel = SEL_CFG;
    else if (addr == UPD_ADDR) sel = SEL_UPD;
    else                       sel = SEL_NONE;
  end
endmodule

// File: rtl/dac_chan_reg.sv
module dac_chan_reg #(
  parameter int CODE_W = 12,
  localparam int HI_W = CODE_W - 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [7:0]        wdata,
  input  logic              update,
  input  logic              clr,
  output logic [CODE_W-1:0] stage_q,
  output logic [CODE_W-1:0] code_o
);
  logic [CODE_W-1:0] live_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      live_q  <= '0;
    end else begin
      if (wr_lo)  stage_q[7:0]        <= wdata;
      if (wr_hi)  stage_q[CODE_W-1:8] <= wdata[HI_W-1:0];
      if (update) live_q              <= stage_q;
    end
  end

  // cleared channel shows zero, stored live code is untouched
  assign code_o = clr ? '0 : live_q;
endmodule

// File: rtl/dac_rd_mux.sv
module dac_rd_mux
  import dac_bank_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int CODE_W = 12,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic [NUM_CH*CODE_W-1:0] stage_flat,
  input  logic [NUM_CH*CODE_W-1:0] live_flat,
  input  reg_sel_e                 sel,
  input  logic [CH_W-1:0]          ch,
  input  logic                     hi,
  input  logic                     rb_live,
  output logic [7:0]               rdata
);
  logic [CODE_W-1:0] stage_a [NUM_CH];
  logic [CODE_W-1:0] live_a  [NUM_CH];
  logic [CODE_W-1:0] word;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_unpack
    assign stage_a[g] = stage_flat[g*CODE_W +: CODE_W];
    assign live_a[g]  = live_flat[g*CODE_W +: CODE_W];
  end

  assign word = rb_live ? live_a[ch] : stage_a[ch];

  always_comb begin
    unique case (sel)
      SEL_DATA: rdata = hi ? 8'(word[CODE_W-1:8]) : word[7:0];
      SEL_CFG:  rdata = {7'b0, rb_live};
      default:  rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/dac_dbuf_bank.sv
module dac_dbuf_bank
  import dac_bank_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int CODE_W = 12,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h50,
  parameter logic [ADDR_W-1:0] CFG_ADDR  = 8'h01,
  parameter logic [ADDR_W-1:0] UPD_ADDR  = 8'h0F
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_write,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [7:0]               req_wdata,
  output logic                     rsp_valid,
  input  logic                     rsp_ready,
  output logic [7:0]               rsp_rdata,
  input  logic [NUM_CH-1:0]        clr_ch,
  output logic [NUM_CH*CODE_W-1:0] dac_code
);
  localparam int CH_W = $clog2(NUM_CH);

  reg_sel_e              sel;
  logic [CH_W-1:0]       ch;
  logic                  hi;
  logic                  accept, wr_en, rd_en, upd_cmd;
  logic                  rb_live;
  logic [7:0]            rd_byte;
  logic [NUM_CH*CODE_W-1:0] stage_flat;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign wr_en     = accept && req_write;
  assign rd_en     = accept && !req_write;
  assign upd_cmd   = wr_en && (sel == SEL_UPD) && req_wdata[0];

  dac_addr_dec #(
    .ADDR_W(ADDR_W), .NUM_CH(NUM_CH), .BASE_ADDR(BASE_ADDR),
    .CFG_ADDR(CFG_ADDR), .UPD_ADDR(UPD_ADDR)
  ) u_dec (
    .addr(req_addr), .sel(sel), .ch(ch), .hi(hi)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic hit;
    assign hit = wr_en && (sel == SEL_DATA) && (ch == CH_W'(g));
    dac_chan_reg #(.CODE_W(CODE_W)) u_chan (
      .clk(clk), .rst_n(rst_n),
      .wr_lo(hit && !hi), .wr_hi(hit && hi),
      .wdata(req_wdata), .update(upd_cmd), .clr(clr_ch[g]),
      .stage_q(stage_flat[g*CODE_W +: CODE_W]),
      .code_o(dac_code[g*CODE_W +: CODE_W])
    );
  end

  dac_rd_mux #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) u_mux (
    .stage_flat(stage_flat), .live_flat(dac_code),
    .sel(sel), .ch(ch), .hi(hi), .rb_live(rb_live), .rdata(rd_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rb_live   <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_rdata <= 8'h00;
    end else begin
      if (wr_en && sel == SEL_CFG) rb_live <= req_wdata[0];
      if (rd_en) begin
        rsp_valid <= 1'b1;
        rsp_rdata <= rd_byte;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dac_dbuf_bank_chk.sv
module dac_dbuf_bank_chk #(
  parameter int NUM_CH = 16,
  parameter int CODE_W = 12,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h50,
  parameter logic [ADDR_W-1:0] UPD_ADDR  = 8'h0F
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     req_valid,
  input logic                     req_ready,
  input logic                     req_write,
  input logic [ADDR_W-1:0]        req_addr,
  input logic                     wbit0,
  input logic                     rsp_valid,
  input logic                     rsp_ready,
  input logic [7:0]               rsp_rdata,
  input logic [NUM_CH-1:0]        clr_ch,
  input logic [NUM_CH*CODE_W-1:0] dac_code
);
  localparam int HI_W = CODE_W - 8;
  logic [ADDR_W-1:0] off;
  logic rd_fire, upd_fire, hi_rd;

  assign off      = req_addr - BASE_ADDR;
  assign rd_fire  = req_valid && req_ready && !req_write;
  assign upd_fire = req_valid && req_ready && req_write && (req_addr == UPD_ADDR) && wbit0;
  assign hi_rd    = rd_fire && (req_addr >= BASE_ADDR) &&
                    ({1'b0, off} < (ADDR_W+1)'(2*NUM_CH)) && off[0];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_clr
    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      clr_ch[g] |-> dac_code[g*CODE_W +: CODE_W] == '0); // R7
  end

  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_fire |=> (!$stable(clr_ch) || $stable(dac_code))); // R3
  AST_UPD_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire && req_addr == UPD_ADDR |=> rsp_rdata == 8'h00); // R5
  AST_HI_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    hi_rd |=> rsp_rdata[7:HI_W] == '0); // R2
  AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> rsp_valid); // R9
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata)); // R9
  AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready); // R9
endmodule

bind dac_dbuf_bank dac_dbuf_bank_chk #(
  .NUM_CH(NUM_CH), .CODE_W(CODE_W), .ADDR_W(ADDR_W),
  .BASE_ADDR(BASE_ADDR), .UPD_ADDR(UPD_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_addr(req_addr), .wbit0(req_wdata[0]),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
  .clr_ch(clr_ch), .dac_code(dac_code)
);

// File: tb/tb_dac_dbuf_bank.sv
module tb_dac_dbuf_bank;
  localparam int NCH = 16;
  localparam int CW  = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [7:0] req_addr = '0, req_wdata = '0;
  logic req_ready, rsp_valid;
  logic [7:0] rsp_rdata;
  logic [NCH-1:0] clr_ch = '0;
  logic [NCH*CW-1:0] dac_code;

  int checks = 0, errors = 0, cyc = 0;
  logic [7:0] exp_q[$];
  string      req_q[$];

  always #2 clk = ~clk;

  dac_dbuf_bank dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .clr_ch(clr_ch), .dac_code(dac_code)
  );

  task automatic check(string rq, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic bus_req(bit wr, logic [7:0] a, logic [7:0] d);
    @(posedge clk); #1;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) begin @(posedge clk); #1; end
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    bus_req(1'b1, a, d);
  endtask

  task automatic rd(logic [7:0] a, logic [7:0] e, string rq);
    exp_q.push_back(e);
    req_q.push_back(rq);
    bus_req(1'b0, a, 8'h00);
  endtask

  task automatic chk_code(int ch, int e, string rq);
    @(negedge clk);
    check(rq, int'(dac_code[ch*CW +: CW]), e);
  endtask

  // monitor: pops expected read bytes as responses are taken
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) check("R9 unexpected response", 1, 0);
      else check(req_q.pop_front(), int'(rsp_rdata), int'(exp_q.pop_front()));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL R9 watchdog actual=%0d expected<20000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    @(negedge clk);
    check("R1 all codes zero", int'(dac_code == '0), 1);
    check("R1 no response pending", int'(rsp_valid), 0);
    rd(8'h01, 8'h00, "R1 readback selects staging");
    rd(8'h56, 8'h00, "R1 staging zero");
    // R2 / R3 staging writes
    wr(8'h50, 8'hAB);
    wr(8'h51, 8'hFC);
    rd(8'h51, 8'h0C, "R2 high byte upper bits zero");
    rd(8'h50, 8'hAB, "R2 low byte");
    rd(8'h52, 8'h00, "R3 neighbour staging untouched");
    chk_code(0, 0, "R3 output unchanged by write");
    // R4 update
    wr(8'h0F, 8'h00);
    chk_code(0, 0, "R4 bit0 clear no update");
    wr(8'h0F, 8'h01);
    chk_code(0, 12'hCAB, "R4 update copies to output");
    rd(8'h0F, 8'h00, "R5 update register reads zero");
    // R6 readback source, last channel
    wr(8'h6E, 8'h34);
    wr(8'h6F, 8'h05);
    wr(8'h01, 8'h01);
    rd(8'h01, 8'h01, "R6 config reads back");
    rd(8'h6E, 8'h00, "R6 live read before update");
    wr(8'h0F, 8'h01);
    rd(8'h6E, 8'h34, "R6 live low after update");
    rd(8'h6F, 8'h05, "R6 live high after update");
    chk_code(15, 12'h534, "R4 last channel output");
    // R7 / R8 clear, update while cleared
    @(posedge clk); #1 clr_ch[0] = 1'b1;
    chk_code(0, 0, "R7 cleared output zero");
    chk_code(15, 12'h534, "R7 other channel unaffected");
    rd(8'h50, 8'h00, "R7 live read zero while cleared");
    wr(8'h50, 8'h11);
    wr(8'h0F, 8'h01);
    chk_code(0, 0, "R8 output stays zero after update in clear");
    rd(8'h50, 8'h00, "R8 live read still zero");
    wr(8'h01, 8'h00);
    rd(8'h50, 8'h11, "R7 staging read unaffected by clear");
    @(posedge clk); #1 clr_ch[0] = 1'b0;
    chk_code(0, 12'hC11, "R8 new code after clear release");
    // R9 back-pressure
    @(posedge clk); #1 rsp_ready = 1'b0;
    exp_q.push_back(8'h34); req_q.push_back("R9 held response data");
    bus_req(1'b0, 8'h6E, 8'h00);
    repeat (3) @(negedge clk);
    check("R9 response held valid", int'(rsp_valid), 1);
    check("R9 ready low while stalled", int'(req_ready), 0);
    check("R9 data stable", int'(rsp_rdata), 8'h34);
    @(posedge clk); #1 rsp_ready = 1'b1;
    // R10 unmapped addresses
    wr(8'h70, 8'hFF);
    wr(8'h4F, 8'hFF);
    rd(8'h70, 8'h00, "R10 unmapped read zero");
    rd(8'h4F, 8'h00, "R10 unmapped below base");
    rd(8'h6F, 8'h05, "R10 last channel untouched");
    rd(8'h50, 8'h11, "R10 first channel untouched");
    chk_code(0, 12'hC11, "R10 output unchanged");
    repeat (4) @(negedge clk);
    check("R9 all responses seen", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule